// File: doc/BRIEF.md
# AC97 Transmit Slot Tag Generator

This block builds the tag slot (slot 0) of every outgoing AC97 frame. It also serves the 20-bit payload of slots 1 to 12 to the serial shifter. Each of the twelve payload slots has its own small FIFO of four 20-bit entries, seen as two blocks of two. A write port fills one FIFO per cycle, chosen by slot number.

When the frame sync pulse arrives, the block latches one valid flag per slot. Slots 1 and 2 carry the command address and the command data. Their flags follow whether those FIFOs hold anything. For slots 3 to 12 a mode input picks the source of the flags. In the older mode a software tag register supplies them. In the newer mode they come from the slot requests that the receive side captured when its last frame ended.

The latched flags give a 16-bit tag word, which also carries the frame-valid bit. When the shifter asks for a slot, it gets the FIFO head if that slot is valid and holds data. Otherwise it gets zeros, and no FIFO is popped.

Top module: `ac97_tx_tagger`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tag_word` and `slot_data` are zero, every bit of `fifo_empty` and `blk_free` is 1, and every bit of `fifo_full` is 0.
- R2: With `ver_new` low, a `frame_sync` pulse loads the valid flag of slot s (3..12) from `tag_reg[s-3]`. The flag of slot s sits at `tag_word` bit 15-s, so slot 3 is at bit 12 and slot 12 is at bit 3.
- R3: With `ver_new` high, the flags of slots 3..12 come from the value of `rx_slot_req` held at the last `rx_frame_end` pulse, mapped as in R2. A `rx_frame_end` in the same cycle as `frame_sync` only affects later frames.
- R4: `tag_word` bit 15 is 1 exactly when any of bits 14..3 is 1. Bits 2..0 are always 0.
- R5: On `frame_sync`, bit 14 (slot 1) is set when the slot 1 FIFO is not empty, and bit 13 (slot 2) is set when the slot 2 FIFO is not empty.
- R6: `tag_word` changes only on the cycle after a `frame_sync` pulse. Changes to `tag_reg`, `ver_new` or `rx_slot_req` between pulses do not show.
- R7: Each slot FIFO holds 4 entries. A write to a full FIFO is dropped. `fifo_empty[s-1]` and `fifo_full[s-1]` report the state of the FIFO for slot s. `wr_slot` gives the slot number, 1..12.
- R8: A `slot_req` for a slot that is valid in the current frame and holds data puts the oldest entry on `slot_data` in the next cycle and removes it from the FIFO, in write order.
- R9: A `slot_req` for a slot whose flag is 0 in the current frame gives `slot_data` = 0 and leaves that FIFO unchanged.
- R10: A `slot_req` for a valid slot whose FIFO is empty gives `slot_data` = 0.
- R11: `blk_free[s-1]` is 1 when the FIFO for slot s holds at most 2 entries, which leaves one two-entry block free.
- R12: A `slot_req` with `slot_idx` 0 or above 12 gives `slot_data` = 0 and pops nothing. Without `slot_req`, `slot_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ver_new | input | 1 | 1: newer mode, flags from received slot requests; 0: flags from tag register |
| tag_reg | input | 10 | Software valid flags; bit i is slot i+3 |
| rx_slot_req | input | 10 | Slot requests decoded from the receive frame; bit i is slot i+3 |
| rx_frame_end | input | 1 | Pulse at end of a receive frame; captures `rx_slot_req` |
| frame_sync | input | 1 | Pulse at start of a transmit frame; latches the flags |
| wr_valid | input | 1 | Write strobe for a slot FIFO |
| wr_slot | input | 4 | Slot number (1..12) of the write |
| wr_data | input | SLOT_W | Write data |
| slot_req | input | 1 | Shifter request for one slot's payload |
| slot_idx | input | 4 | Slot number of the request |
| tag_word | output | 16 | Tag slot of the current frame |
| slot_data | output | SLOT_W | Payload returned for the last request |
| fifo_empty | output | 12 | Per-slot FIFO empty |
| fifo_full | output | 12 | Per-slot FIFO full |
| blk_free | output | 12 | Per-slot FIFO has a free block |

## Verification
The assertions assume that `frame_sync`, `rx_frame_end`, `slot_req` and `wr_valid` are single-cycle strobes sampled on the clock. They also assume that any `slot_idx` used with `slot_req` is a plain 4-bit number. Out-of-range slot numbers are legal and expected to return zeros.

The random stimulus raises at most one of these strobes per cycle. The exception is a directed case that raises `rx_frame_end` together with `frame_sync` to check the ordering in R3. Slot numbers are drawn from 0..13, so the out-of-range cases are covered. Writes go to full FIFOs often enough that the drop rule of R7 is exercised.

// File: rtl/ac97tx_pkg.sv
package ac97tx_pkg;
  localparam int NSLOT = 12;          // payload slots 1..12
  localparam int NREQ  = NSLOT - 2;   // slots 3..12 with selectable flags
  localparam int TAG_W = 16;
  localparam int IDX_W = 4;

  // flags v[i] belong to slot i+1; slot s lands on bit 15-s
  function automatic logic [TAG_W-1:0] pack_tag(input logic [NSLOT-1:0] v);
    logic [TAG_W-1:0] t;
    t = '0;
    for (int i = 0; i < NSLOT; i++) t[TAG_W-2-i] = v[i];
    t[TAG_W-1] = |v;
    return t;
  endfunction
endpackage

// File: rtl/ac97tx_slot_fifo.sv
module ac97tx_slot_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         half_free
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));
  assign half_free = (cnt <= CW'(HALF));
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ac97tx_valid_sel.sv
module ac97tx_valid_sel
  import ac97tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ver_new,
  input  logic [NREQ-1:0]  tag_reg,
  input  logic [NREQ-1:0]  rx_req,
  input  logic             rx_frame_end,
  input  logic             frame_sync,
  input  logic             cmd_addr_avail,
  input  logic             cmd_data_avail,
  output logic [NSLOT-1:0] vflag,
  output logic [TAG_W-1:0] tag_word
);
  logic [NREQ-1:0]  req_q;
  logic [NREQ-1:0]  data_flags;
  logic [NSLOT-1:0] next_flags;

  always_comb begin
    data_flags = ver_new ? req_q : tag_reg;
    next_flags = {data_flags, cmd_data_avail, cmd_addr_avail};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      vflag    <= '0;
      tag_word <= '0;
    end else begin
      if (rx_frame_end) req_q <= rx_req;
      if (frame_sync) begin
        vflag    <= next_flags;
        tag_word <= pack_tag(next_flags);
      end
    end
  end
endmodule

// File: rtl/ac97tx_slot_mux.sv
module ac97tx_slot_mux #(
  parameter int W  = 20,
  parameter int NS = 12,
  parameter int IW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot_req,
  input  logic [IW-1:0]   slot_idx,
  input  logic [NS-1:0]   vflag,
  input  logic [NS*W-1:0] heads,
  input  logic [NS-1:0]   empty,
  output logic [NS-1:0]   pop,
  output logic [W-1:0]    slot_data
);
  logic [W-1:0] nxt;

  for (genvar g = 0; g < NS; g++) begin : g_pop
    assign pop[g] = slot_req && (slot_idx == IW'(g + 1)) && vflag[g] && !empty[g];
  end

  always_comb begin
    nxt = '0;
    for (int i = 0; i < NS; i++)
      if (pop[i]) nxt = nxt | heads[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst)           slot_data <= '0;
    else if (slot_req) slot_data <= nxt;
  end
endmodule

// File: rtl/ac97_tx_tagger.sv
module ac97_tx_tagger
  import ac97tx_pkg::*;
#(
  parameter int SLOT_W     = 20,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ver_new,
  input  logic [9:0]        tag_reg,
  input  logic [9:0]        rx_slot_req,
  input  logic              rx_frame_end,
  input  logic              frame_sync,
  input  logic              wr_valid,
  input  logic [3:0]        wr_slot,
  input  logic [SLOT_W-1:0] wr_data,
  input  logic              slot_req,
  input  logic [3:0]        slot_idx,
  output logic [15:0]       tag_word,
  output logic [SLOT_W-1:0] slot_data,
  output logic [11:0]       fifo_empty,
  output logic [11:0]       fifo_full,
  output logic [11:0]       blk_free
);
  logic [NSLOT-1:0]        vflag;
  logic [NSLOT-1:0]        pop;
  logic [NSLOT*SLOT_W-1:0] heads;

  for (genvar g = 0; g < NSLOT; g++) begin : g_fifo
    logic push_g;
    assign push_g = wr_valid && (wr_slot == IDX_W'(g + 1));
    ac97tx_slot_fifo #(.W(SLOT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (push_g),
      .din       (wr_data),
      .pop       (pop[g]),
      .head      (heads[g*SLOT_W +: SLOT_W]),
      .empty     (fifo_empty[g]),
      .full      (fifo_full[g]),
      .half_free (blk_free[g])
    );
  end

  ac97tx_valid_sel u_vsel (
    .clk            (clk),
    .rst            (rst),
    .ver_new        (ver_new),
    .tag_reg        (tag_reg),
    .rx_req         (rx_slot_req),
    .rx_frame_end   (rx_frame_end),
    .frame_sync     (frame_sync),
    .cmd_addr_avail (!fifo_empty[0]),
    .cmd_data_avail (!fifo_empty[1]),
    .vflag          (vflag),
    .tag_word       (tag_word)
  );

  ac97tx_slot_mux #(.W(SLOT_W), .NS(NSLOT), .IW(IDX_W)) u_mux (
    .clk       (clk),
    .rst       (rst),
    .slot_req  (slot_req),
    .slot_idx  (slot_idx),
    .vflag     (vflag),
    .heads     (heads),
    .empty     (fifo_empty),
    .pop       (pop),
    .slot_data (slot_data)
  );
endmodule

// File: rtl/ac97tx_chk.sv
module ac97tx_chk #(
  parameter int SLOT_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_sync,
  input logic              slot_req,
  input logic [3:0]        slot_idx,
  input logic [15:0]       tag_word,
  input logic [SLOT_W-1:0] slot_data,
  input logic [11:0]       fifo_empty,
  input logic [11:0]       fifo_full
);
  // R4
  tag_format_chk: assert property (@(posedge clk) disable iff (rst)
    (tag_word[2:0] == 3'b000) && (tag_word[15] == (|tag_word[14:3])));

  // R6
  tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_sync |=> $stable(tag_word));

  // R5
  cmd_addr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> tag_word[14] == !$past(fifo_empty[0]));

  // R7
  no_full_and_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_full & fifo_empty) == 12'd0);

  // R9
  invalid_slot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_req && slot_idx >= 4'd1 && slot_idx <= 4'd12 && !tag_word[4'd15 - slot_idx])
      |=> slot_data == '0);

  // R12
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !slot_req |=> $stable(slot_data));

  // R12
  bad_index_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_req && (slot_idx == 4'd0 || slot_idx > 4'd12)) |=> slot_data == '0);
endmodule

bind ac97_tx_tagger ac97tx_chk #(.SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/sim_ac97_tx_tagger.sv
module sim_ac97_tx_tagger;
  logic        clk = 1'b0, rst = 1'b1;
  logic        ver_new = 1'b0, rx_frame_end = 1'b0, frame_sync = 1'b0;
  logic [9:0]  tag_reg = '0, rx_slot_req = '0;
  logic        wr_valid = 1'b0, slot_req = 1'b0;
  logic [3:0]  wr_slot = '0, slot_idx = '0;
  logic [19:0] wr_data = '0;
  logic [15:0] tag_word;
  logic [19:0] slot_data;
  logic [11:0] fifo_empty, fifo_full, blk_free;

  always #5 clk = ~clk;

  ac97_tx_tagger u0 (.*);

  int n_tests = 0, n_fail = 0;
  logic [19:0] m_mem [12][4];
  int          m_rd [12];
  int          m_cnt [12];
  logic [11:0] m_v = '0;
  logic [9:0]  m_req = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] exp_tag(input logic [11:0] v);
    logic [15:0] t = '0;
    for (int s = 1; s <= 12; s++) t[15-s] = v[s-1];
    t[15] = (v != 12'd0);
    return t;
  endfunction

  task automatic check_flags(input string req);
    logic [11:0] e, f, b;
    for (int i = 0; i < 12; i++) begin
      e[i] = (m_cnt[i] == 0);
      f[i] = (m_cnt[i] == 4);
      b[i] = (m_cnt[i] <= 2);
    end
    chk({req, " R7 empty"}, {20'd0, fifo_empty}, {20'd0, e});
    chk({req, " R7 full"}, {20'd0, fifo_full}, {20'd0, f});
    chk({req, " R11 blk_free"}, {20'd0, blk_free}, {20'd0, b});
  endtask

  task automatic push(input int s, input logic [19:0] d);
    wr_valid = 1'b1; wr_slot = 4'(s); wr_data = d;
    if (m_cnt[s-1] < 4) begin
      m_mem[s-1][(m_rd[s-1] + m_cnt[s-1]) % 4] = d;
      m_cnt[s-1]++;
    end
    step();
    wr_valid = 1'b0;
  endtask

  task automatic frame(input string req, input bit with_rx, input logic [9:0] rq);
    logic [11:0] v;
    v[0] = (m_cnt[0] > 0);
    v[1] = (m_cnt[1] > 0);
    v[11:2] = ver_new ? m_req : tag_reg;
    frame_sync = 1'b1;
    rx_frame_end = with_rx; rx_slot_req = rq;
    step();
    frame_sync = 1'b0; rx_frame_end = 1'b0;
    if (with_rx) m_req = rq;
    m_v = v;
    chk({req, " tag"}, {16'd0, tag_word}, {16'd0, exp_tag(v)});
  endtask

  task automatic rx_end(input logic [9:0] rq);
    rx_frame_end = 1'b1; rx_slot_req = rq;
    step();
    rx_frame_end = 1'b0;
    m_req = rq;
  endtask

  task automatic request(input string req, input int s);
    logic [19:0] e = '0;
    if (s >= 1 && s <= 12 && m_v[s-1] && m_cnt[s-1] > 0) begin
      e = m_mem[s-1][m_rd[s-1]];
      m_rd[s-1] = (m_rd[s-1] + 1) % 4;
      m_cnt[s-1]--;
    end
    slot_req = 1'b1; slot_idx = 4'(s);
    step();
    slot_req = 1'b0;
    chk({req, " slot_data"}, {12'd0, slot_data}, {12'd0, e});
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A97));
    for (int i = 0; i < 12; i++) begin m_rd[i] = 0; m_cnt[i] = 0; end
    @(negedge clk);
    repeat (3) step();
    chk("R1 tag in reset", {16'd0, tag_word}, 32'd0);
    rst = 1'b0;
    step();
    chk("R1 tag", {16'd0, tag_word}, 32'd0);
    chk("R1 data", {12'd0, slot_data}, 32'd0);
    check_flags("R1");

    // R2 older mode, single slots at edges
    tag_reg = 10'b00_0000_0001; frame("R2 slot3", 0, '0);
    chk("R2 slot3 bit12", {16'd0, tag_word}, 32'h9000);
    tag_reg = 10'b10_0000_0000; frame("R2 slot12", 0, '0);
    chk("R2 slot12 bit3", {16'd0, tag_word}, 32'h8008);
    tag_reg = '0; frame("R4 all off", 0, '0);
    chk("R4 frame invalid", {16'd0, tag_word}, 32'd0);

    // R6 inputs change without sync
    tag_reg = 10'h3FF; ver_new = 1'b1; rx_slot_req = 10'h155;
    step(); step();
    chk("R6 tag held", {16'd0, tag_word}, 32'd0);
    ver_new = 1'b0;

    // R5 command fifos
    push(1, 20'hA0001); push(2, 20'hB0002);
    tag_reg = '0; frame("R5 cmd", 0, '0);
    chk("R5 slots1-2", {16'd0, tag_word}, 32'hE000);
    request("R8 slot1", 1);
    request("R10 slot1 empty", 1);
    request("R8 slot2", 2);

    // R3 newer mode and same-cycle ordering
    ver_new = 1'b1;
    rx_end(10'h2A5);
    frame("R3 req", 1, 10'h00F);
    frame("R3 later", 0, '0);
    ver_new = 1'b0;

    // R7 overflow, R8 order, R9 invalid slot, R11
    for (int k = 0; k < 5; k++) push(5, 20'h50000 + 20'(k));
    check_flags("R7 overflow");
    tag_reg = '0; frame("R9 setup", 0, '0);
    request("R9 invalid slot5", 5);
    check_flags("R9 no pop");
    tag_reg = 10'b00_0000_0100; frame("R8 setup", 0, '0);
    for (int k = 0; k < 5; k++) request("R8 order", 5);
    check_flags("R11 after drain");
    request("R12 idx0", 0);
    request("R12 idx13", 13);

    // random mix
    for (int it = 0; it < 1500; it++) begin
      case ($urandom_range(0, 5))
        0, 1: push(int'($urandom_range(1, 12)), 20'($urandom));
        2: begin
          tag_reg = 10'($urandom);
          ver_new = 1'($urandom);
          frame("R2/R3/R5 rand", 0, '0);
        end
        3: rx_end(10'($urandom));
        default: request("R8/R9/R10/R12 rand", int'($urandom_range(0, 13)));
      endcase
      if (it % 50 == 0) check_flags("R7/R11 rand");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule